// File: doc/BRIEF.md
# Interleaved ADC output demultiplexer

This block is the digital output formatting stage of a two-core sampling converter. One core converts the I input and the other converts the Q input. The block collects their 8-bit words and presents them on four parallel output buses: an I bus, a delayed I bus, a Q bus and a delayed Q bus. An output strobe marks each update, and an output data clock goes with it. The block runs on one clock, `clk`, at twice the input-clock rate, so every `clk` edge is one half-period of the input clock. After each restart of the internal phase counter, even-numbered edges count as falling-edge samples and odd-numbered edges as rising-edge samples.

In normal mode each core samples on falling edges only, and each channel is split 1:2 over its current bus and its delayed bus. In dual-edge mode a single chosen input is sampled on every edge: the I core takes the falling edges and the Q core takes the rising edges. The four buses then carry four consecutive samples. Control comes either from pins or from register values, and `ctrl_ext` chooses between the two sources. Any change of the source, of dual-edge mode or of the input selection flushes the data path.

Top module: `adc_ilv_demux`

## Requirements
- R1: While `rst` is high, and at the first sample after it, all four buses are 0 and `out_vld`, `out_stb` and `dclk` are 0.
- R2: `out_stb` is high for one `clk` cycle in every 4 (one update every two input-clock cycles), and the buses change only at a strobe or at a flush.
- R3: In normal mode, at an update made on edge u, `bus_i` holds the I input from edge u-26 (13 input cycles) and `bus_id` holds it from edge u-28 (14 cycles). `bus_q` and `bus_qd` hold the Q input from the same two edges.
- R4: In dual-edge mode, at an update made on edge u, the buses hold the chosen input from these edges: `bus_qd` from u-29, `bus_id` from u-28, `bus_q` from u-27 and `bus_i` from u-26. Read in that bus order, the samples run from earliest to latest.
- R5: Under pin control (`ctrl_ext`=0), dual-edge mode (`pin_des`=1) always samples the I input, and `reg_qsel` has no effect.
- R6: Under register control (`ctrl_ext`=1) with `reg_des`=1, `reg_qsel`=1 chooses the Q input and `reg_qsel`=0 chooses the I input.
- R7: Under register control, `pin_des`, `pin_ddr`, `pin_oedge`, `pin_fsr` and `pin_outv` are ignored. `fsr_sel` and `outv_sel` follow the `reg_fsr` and `reg_outv` values of the previous cycle, and changing a pin causes no flush.
- R8: In single-rate output (ddr=0), `dclk` equals the edge select (1 = data changes on the rising edge of `dclk`) in the cycle of a strobe and equals its inverse two cycles later.
- R9: In double-rate output (ddr=1), `dclk` toggles at every update, so data changes on both of its edges.
- R10: Any change of `ctrl_ext`, of the effective dual-edge bit or of the effective input selection clears the buses and `out_vld` at that edge. The next update with `out_vld`=1 is made 33 edges later, the first one at which all latency taps hold post-flush samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period clock (twice the input-clock rate) |
| rst | input | 1 | Synchronous active-high reset |
| ana_i | input | 8 | I-input sample word for this edge |
| ana_q | input | 8 | Q-input sample word for this edge |
| ctrl_ext | input | 1 | 1 = register control, 0 = pin control |
| pin_des | input | 1 | Dual-edge enable, pin source |
| pin_ddr | input | 1 | Double-rate output, pin source |
| pin_oedge | input | 1 | Output edge select, pin source |
| pin_fsr | input | 1 | Full-scale select, pin source |
| pin_outv | input | 1 | Output swing select, pin source |
| reg_des | input | 1 | Dual-edge enable, register source |
| reg_qsel | input | 1 | Dual-edge input select (1 = Q), register source |
| reg_ddr | input | 1 | Double-rate output, register source |
| reg_oedge | input | 1 | Output edge select, register source |
| reg_fsr | input | 1 | Full-scale select, register source |
| reg_outv | input | 1 | Output swing select, register source |
| bus_qd | output | 8 | Delayed Q bus |
| bus_id | output | 8 | Delayed I bus |
| bus_q | output | 8 | Q bus |
| bus_i | output | 8 | I bus |
| out_stb | output | 1 | Output update strobe |
| out_vld | output | 1 | Buses hold post-flush data |
| dclk | output | 1 | Output data clock |
| fsr_sel | output | 1 | Selected full-scale setting |
| outv_sel | output | 1 | Selected output swing setting |

## Verification
The bench numbers every `clk` edge and drives each input as a fixed function of that number. At a strobe seen after edge u it therefore expects the words from edges u-26 and u-28, or u-26 to u-29 in dual-edge mode, with no history kept in the bench. Each result is sampled on the falling edge of `clk` that follows the registering edge. The data clock level is checked at the strobe and again two edges later. After a mode change, every strobe up to edge F+32 must show `out_vld` low, and the strobe made on edge F+33 must show it high.

// File: rtl/adc_ilv_pkg.sv
package adc_ilv_pkg;
   // Effective data-path and output-clock mode after the control source mux
   typedef struct packed {
      logic des;    // dual-edge sampling
      logic qsel;   // dual-edge input is Q
      logic ddr;    // double-rate output clock
      logic oedge;  // data changes on the rising dclk edge
   } dp_mode_t;

   // Edges between output updates (two input-clock cycles)
   localparam int unsigned FRAME_EDGES = 4;
endpackage

// File: rtl/adc_ctrl_src.sv
module adc_ctrl_src
   import adc_ilv_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     ctrl_ext,
   input  logic     pin_des,
   input  logic     pin_ddr,
   input  logic     pin_oedge,
   input  logic     pin_fsr,
   input  logic     pin_outv,
   input  logic     reg_des,
   input  logic     reg_qsel,
   input  logic     reg_ddr,
   input  logic     reg_oedge,
   input  logic     reg_fsr,
   input  logic     reg_outv,
   output dp_mode_t mode,
   output logic     fsr_sel,
   output logic     outv_sel,
   output logic     flush
);
   logic prev_ext, prev_des, prev_qsel;

   always_comb begin
      if (ctrl_ext) begin
         mode.des   = reg_des;
         mode.qsel  = reg_des & reg_qsel;
         mode.ddr   = reg_ddr;
         mode.oedge = reg_oedge;
      end else begin
         mode.des   = pin_des;
         mode.qsel  = 1'b0;          // pin control samples I only
         mode.ddr   = pin_ddr;
         mode.oedge = pin_oedge;
      end
   end

   // Static settings: plain retiming flops, no reset needed
   always_ff @(posedge clk) begin
      fsr_sel  <= ctrl_ext ? reg_fsr  : pin_fsr;
      outv_sel <= ctrl_ext ? reg_outv : pin_outv;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_ext  <= 1'b0;
         prev_des  <= 1'b0;
         prev_qsel <= 1'b0;
      end else begin
         prev_ext  <= ctrl_ext;
         prev_des  <= mode.des;
         prev_qsel <= mode.qsel;
      end
   end

   assign flush = !rst && ({ctrl_ext, mode.des, mode.qsel} != {prev_ext, prev_des, prev_qsel});
endmodule

// File: rtl/adc_smp_dline.sv
module adc_smp_dline #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 29
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     clr,
   input  logic [W-1:0]             din,
   output logic [DEPTH-1:0][W-1:0]  taps
);
   generate
      if (DEPTH < 2) begin : g_bad
         $error("adc_smp_dline: DEPTH must be at least 2");
      end
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst || clr) taps[0] <= '0;
               else            taps[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst || clr) taps[s] <= '0;
               else            taps[s] <= taps[s-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/adc_out_framer.sv
module adc_out_framer
   import adc_ilv_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned LAT_CYC = 13,
   localparam int unsigned LAT_H  = 2 * LAT_CYC,
   localparam int unsigned DEPTH  = LAT_H + 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  dp_mode_t                mode,
   input  logic [DEPTH-1:0][W-1:0] taps_i,
   input  logic [DEPTH-1:0][W-1:0] taps_q,
   output logic [W-1:0]            bus_qd,
   output logic [W-1:0]            bus_id,
   output logic [W-1:0]            bus_q,
   output logic [W-1:0]            bus_i,
   output logic                    out_stb,
   output logic                    out_vld
   ,output logic                   dclk
);
   localparam int unsigned FILL_W = $clog2(DEPTH + 1);
   localparam int unsigned CNT_W  = $clog2(FRAME_EDGES);
   // tap k holds the word captured (k+1) edges before the current edge
   localparam int unsigned T_NOW  = LAT_H - 1;
   localparam int unsigned T_NOWR = LAT_H;
   localparam int unsigned T_OLD  = LAT_H + 1;
   localparam int unsigned T_OLDR = LAT_H + 2;

   logic [CNT_W-1:0]  ph_cnt;
   logic [FILL_W-1:0] fill;
   logic [W-1:0]      nx_qd, nx_id, nx_q, nx_i;
   logic              upd_edge;

   assign upd_edge = (ph_cnt == '0);

   always_comb begin
      nx_i  = taps_i[T_NOW];
      nx_id = taps_i[T_OLD];
      if (mode.des) begin
         nx_q  = taps_q[T_NOWR];   // rising-edge words, half a cycle older
         nx_qd = taps_q[T_OLDR];
      end else begin
         nx_q  = taps_q[T_NOW];
         nx_qd = taps_q[T_OLD];
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         ph_cnt  <= '0;
         fill    <= '0;
         out_stb <= 1'b0;
         out_vld <= 1'b0;
         dclk    <= 1'b0;
         bus_qd  <= '0;
         bus_id  <= '0;
         bus_q   <= '0;
         bus_i   <= '0;
      end else begin
         ph_cnt  <= ph_cnt + 1'b1;
         out_stb <= upd_edge;
         if (fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
         if (upd_edge) begin
            bus_qd  <= nx_qd;
            bus_id  <= nx_id;
            bus_q   <= nx_q;
            bus_i   <= nx_i;
            out_vld <= (fill == FILL_W'(DEPTH));
            dclk    <= mode.ddr ? ~dclk : mode.oedge;
         end else if (ph_cnt == CNT_W'(FRAME_EDGES / 2) && !mode.ddr) begin
            dclk    <= ~mode.oedge;
         end
      end
   end
endmodule

// File: rtl/adc_ilv_demux.sv
module adc_ilv_demux
   import adc_ilv_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter int unsigned LAT_CYC = 13
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ana_i,
   input  logic [W-1:0] ana_q,
   input  logic         ctrl_ext,
   input  logic         pin_des,
   input  logic         pin_ddr,
   input  logic         pin_oedge,
   input  logic         pin_fsr,
   input  logic         pin_outv,
   input  logic         reg_des,
   input  logic         reg_qsel,
   input  logic         reg_ddr,
   input  logic         reg_oedge,
   input  logic         reg_fsr,
   input  logic         reg_outv,
   output logic [W-1:0] bus_qd,
   output logic [W-1:0] bus_id,
   output logic [W-1:0] bus_q,
   output logic [W-1:0] bus_i,
   output logic         out_stb,
   output logic         out_vld,
   output logic         dclk,
   output logic         fsr_sel,
   output logic         outv_sel
);
   localparam int unsigned DEPTH = 2 * LAT_CYC + 3;

   generate
      if (W < 1 || W > 16) begin : g_bad_w
         $error("adc_ilv_demux: W out of range");
      end
      if (LAT_CYC < 1 || LAT_CYC > 64) begin : g_bad_lat
         $error("adc_ilv_demux: LAT_CYC out of range");
      end
   endgenerate

   dp_mode_t mode;
   logic     flush;
   logic [W-1:0] sel_word, word_i, word_q;
   logic [DEPTH-1:0][W-1:0] taps_i, taps_q;

   adc_ctrl_src u_ctrl (
      .clk(clk), .rst(rst), .ctrl_ext(ctrl_ext),
      .pin_des(pin_des), .pin_ddr(pin_ddr), .pin_oedge(pin_oedge),
      .pin_fsr(pin_fsr), .pin_outv(pin_outv),
      .reg_des(reg_des), .reg_qsel(reg_qsel), .reg_ddr(reg_ddr),
      .reg_oedge(reg_oedge), .reg_fsr(reg_fsr), .reg_outv(reg_outv),
      .mode(mode), .fsr_sel(fsr_sel), .outv_sel(outv_sel), .flush(flush)
   );

   // Dual-edge: both cores see the chosen input; otherwise each its own
   assign sel_word = mode.qsel ? ana_q : ana_i;
   assign word_i   = mode.des ? sel_word : ana_i;
   assign word_q   = mode.des ? sel_word : ana_q;

   adc_smp_dline #(.W(W), .DEPTH(DEPTH)) u_line_i (
      .clk(clk), .rst(rst), .clr(flush), .din(word_i), .taps(taps_i)
   );
   adc_smp_dline #(.W(W), .DEPTH(DEPTH)) u_line_q (
      .clk(clk), .rst(rst), .clr(flush), .din(word_q), .taps(taps_q)
   );

   adc_out_framer #(.W(W), .LAT_CYC(LAT_CYC)) u_frame (
      .clk(clk), .rst(rst), .clr(flush), .mode(mode),
      .taps_i(taps_i), .taps_q(taps_q),
      .bus_qd(bus_qd), .bus_id(bus_id), .bus_q(bus_q), .bus_i(bus_i),
      .out_stb(out_stb), .out_vld(out_vld), .dclk(dclk)
   );
endmodule

// File: rtl/adc_ilv_demux_chk.sv
module adc_ilv_demux_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         ctrl_ext,
   input logic         reg_fsr,
   input logic         reg_outv,
   input logic         flush,
   input logic [W-1:0] bus_qd,
   input logic [W-1:0] bus_id,
   input logic [W-1:0] bus_q,
   input logic [W-1:0] bus_i,
   input logic         out_stb,
   input logic         out_vld,
   input logic         fsr_sel,
   input logic         outv_sel
);
   // R2: a strobe never lasts two cycles
   p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
      out_stb |=> !out_stb);

   // R2: no strobe and no flush on the last edge -> buses held
   p_bus_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!out_stb && !$past(flush)) |->
         ($stable(bus_i) && $stable(bus_id) && $stable(bus_q) && $stable(bus_qd)));

   // R10: a flush empties the outputs on the same edge
   p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!out_vld && !out_stb && bus_i == '0 && bus_qd == '0));

   // R10: a flush edge never carries a valid update
   p_flush_no_vld_r10: assert property (@(posedge clk) disable iff (rst)
      flush |=> !out_vld);

   // R7: register source drives the static settings one cycle later
   p_fsr_reg_r7: assert property (@(posedge clk) disable iff (rst)
      $past(ctrl_ext) |-> (fsr_sel == $past(reg_fsr)));

   p_outv_reg_r7: assert property (@(posedge clk) disable iff (rst)
      $past(ctrl_ext) |-> (outv_sel == $past(reg_outv)));
endmodule

bind adc_ilv_demux adc_ilv_demux_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .ctrl_ext(ctrl_ext), .reg_fsr(reg_fsr),
   .reg_outv(reg_outv), .flush(flush),
   .bus_qd(bus_qd), .bus_id(bus_id), .bus_q(bus_q), .bus_i(bus_i),
   .out_stb(out_stb), .out_vld(out_vld), .fsr_sel(fsr_sel), .outv_sel(outv_sel)
);

// File: tb/adc_ilv_demux_test.sv
module adc_ilv_demux_test;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 26;   // 13 input cycles in half-periods

   logic clk = 1'b0;
   logic rst;
   logic [7:0] ana_i, ana_q;
   logic ctrl_ext, pin_des, pin_ddr, pin_oedge, pin_fsr, pin_outv;
   logic reg_des, reg_qsel, reg_ddr, reg_oedge, reg_fsr, reg_outv;
   logic [7:0] bus_qd, bus_id, bus_q, bus_i;
   logic out_stb, out_vld, dclk, fsr_sel, outv_sel;

   int checks = 0;
   int failures = 0;
   int edge_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_ilv_demux uut (
      .clk(clk), .rst(rst), .ana_i(ana_i), .ana_q(ana_q),
      .ctrl_ext(ctrl_ext), .pin_des(pin_des), .pin_ddr(pin_ddr),
      .pin_oedge(pin_oedge), .pin_fsr(pin_fsr), .pin_outv(pin_outv),
      .reg_des(reg_des), .reg_qsel(reg_qsel), .reg_ddr(reg_ddr),
      .reg_oedge(reg_oedge), .reg_fsr(reg_fsr), .reg_outv(reg_outv),
      .bus_qd(bus_qd), .bus_id(bus_id), .bus_q(bus_q), .bus_i(bus_i),
      .out_stb(out_stb), .out_vld(out_vld), .dclk(dclk),
      .fsr_sel(fsr_sel), .outv_sel(outv_sel)
   );

   function automatic logic [7:0] fi(input int k);
      return 8'(k * 5 + 1);
   endfunction
   function automatic logic [7:0] fq(input int k);
      return 8'(k * 7 + 3);
   endfunction

   // edge_n = index of the next rising clk edge
   always @(posedge clk) edge_n <= edge_n + 1;
   always @(negedge clk) begin
      ana_i = fi(edge_n);
      ana_q = fq(edge_n);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_valid_stb();
      for (int n = 0; n < 200; n++) begin
         @(negedge clk);
         if (out_stb && out_vld) return;
      end
      chk(1'b0, "R10 valid timeout", 0, 1);
   endtask

   // Check n valid updates against the stream model
   task automatic watch(input int n_upd, input bit des, input bit selq, input string req);
      int last = -1;
      logic [7:0] hi, hid, hq, hqd;
      wait_valid_stb();
      for (int u = 0; u < n_upd; ) begin
         int e = edge_n - 1;
         if (out_stb) begin
            logic [7:0] ei, eid, eq, eqd;
            if (des) begin
               ei  = selq ? fq(e-LAT)   : fi(e-LAT);
               eid = selq ? fq(e-LAT-2) : fi(e-LAT-2);
               eq  = selq ? fq(e-LAT-1) : fi(e-LAT-1);
               eqd = selq ? fq(e-LAT-3) : fi(e-LAT-3);
            end else begin
               ei = fi(e-LAT); eid = fi(e-LAT-2);
               eq = fq(e-LAT); eqd = fq(e-LAT-2);
            end
            chk(out_vld, {req, " vld"}, int'(out_vld), 1);
            chk(bus_i == ei,   {req, " bus_i"},  bus_i,  ei);
            chk(bus_id == eid, {req, " bus_id"}, bus_id, eid);
            chk(bus_q == eq,   {req, " bus_q"},  bus_q,  eq);
            chk(bus_qd == eqd, {req, " bus_qd"}, bus_qd, eqd);
            if (last >= 0) chk(e - last == 4, "R2 strobe spacing", e - last, 4);
            last = e;
            u++;
         end else if (last >= 0) begin
            chk(bus_i == hi && bus_id == hid && bus_q == hq && bus_qd == hqd,
                "R2 hold between strobes", bus_i, hi);
         end
         hi = bus_i; hid = bus_id; hq = bus_q; hqd = bus_qd;
         @(negedge clk);
      end
   endtask

   task automatic set_all(input bit ext, input bit pdes, input bit rdes, input bit rq);
      @(negedge clk);
      ctrl_ext = ext; pin_des = pdes; reg_des = rdes; reg_qsel = rq;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      ctrl_ext = 0; pin_des = 0; pin_ddr = 0; pin_oedge = 1; pin_fsr = 0; pin_outv = 0;
      reg_des = 0; reg_qsel = 0; reg_ddr = 0; reg_oedge = 1; reg_fsr = 0; reg_outv = 0;
      repeat (4) @(negedge clk);
      chk(bus_i == 0 && bus_id == 0 && bus_q == 0 && bus_qd == 0, "R1 buses in reset", bus_i, 0);
      chk(!out_vld && !out_stb && !dclk, "R1 flags in reset", {out_vld, out_stb, dclk}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!out_vld && bus_i == 0, "R1 first sample after reset", out_vld, 0);
   endtask

   task automatic t_normal();
      set_all(0, 0, 0, 0);
      watch(6, 0, 0, "R3 normal");
   endtask

   task automatic t_des_pin();
      set_all(0, 1, 0, 1);          // reg_qsel set but must not matter
      watch(6, 1, 0, "R4 R5 pin dual-edge I");
   endtask

   task automatic t_des_reg_q();
      set_all(1, 0, 1, 1);
      watch(6, 1, 1, "R4 R6 reg dual-edge Q");
      set_all(1, 0, 1, 0);
      watch(3, 1, 0, "R6 reg dual-edge I");
   endtask

   task automatic t_ext_ignore();
      set_all(1, 0, 0, 0);
      reg_fsr = 1; reg_outv = 0; pin_fsr = 0; pin_outv = 1;
      watch(2, 0, 0, "R7 reg normal");
      @(negedge clk);
      pin_des = 1; pin_ddr = 1; pin_oedge = 0; pin_fsr = 1; pin_outv = 0;
      reg_outv = 1; reg_fsr = 0;
      @(negedge clk);
      chk(fsr_sel == 0 && outv_sel == 1, "R7 settings from registers", {fsr_sel, outv_sel}, 1);
      chk(out_vld, "R7 pin change causes no flush", out_vld, 1);
      watch(4, 0, 0, "R7 pins ignored");
      for (int n = 0; n < 8; n++) begin
         if (out_stb) chk(dclk == 1, "R7 R8 pin edge ignored", dclk, 1);
         @(negedge clk);
      end
      pin_des = 0; pin_ddr = 0; pin_oedge = 1;
   endtask

   task automatic t_sdr(input bit oe);
      int seen = 0;
      set_all(0, 0, 0, 0);
      pin_ddr = 0; pin_oedge = oe;
      wait_valid_stb();
      while (seen < 3) begin
         if (out_stb) begin
            chk(dclk == oe, "R8 dclk at strobe", dclk, oe);
            repeat (2) @(negedge clk);
            chk(dclk == !oe, "R8 dclk mid frame", dclk, !oe);
            seen++;
         end else @(negedge clk);
      end
   endtask

   task automatic t_ddr();
      logic prev = 1'b0;
      int seen = 0;
      set_all(1, 0, 0, 0);
      reg_ddr = 1;
      wait_valid_stb();
      prev = dclk;
      @(negedge clk);
      while (seen < 4) begin
         if (out_stb) begin
            chk(dclk != prev, "R9 dclk toggles per update", dclk, !prev);
            prev = dclk;
            seen++;
         end
         @(negedge clk);
      end
      reg_ddr = 0;
   endtask

   task automatic t_flush();
      int f;
      set_all(0, 0, 0, 0);
      wait_valid_stb();
      @(negedge clk);
      pin_des = 1;
      f = edge_n;                    // flush edge
      @(negedge clk);
      chk(!out_vld && bus_i == 0 && bus_qd == 0, "R10 cleared at flush", bus_i, 0);
      while (edge_n - 1 < f + 33) begin
         if (out_stb) chk(!out_vld, "R10 invalid during refill", out_vld, 0);
         @(negedge clk);
      end
      chk(out_stb && out_vld, "R10 first valid update at F+33",
          {out_stb, out_vld}, 3);
      watch(2, 1, 0, "R10 data after flush");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_normal();
      t_des_pin();
      t_des_reg_q();
      t_ext_ignore();
      t_sdr(1'b1);
      t_sdr(1'b0);
      t_ddr();
      t_flush();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule